// File: doc/BRIEF.md
# Triggered Acquisition Sequencer

This block decides when a sampling converter is told to start. Pacer ticks from an external timer arrive at a steady rate, and the sequencer passes them on as convert-start pulses only when the selected acquisition mode allows it. It supports several modes. One starts a single conversion on a software command. One runs freely for as long as conversion is armed. Three others fix the capture window around an external trigger: the window can end at the trigger, begin at it, or straddle it with a programmed share on either side.

Software drives single-cycle strobes to command a conversion, arm, halt and clear flags. A 3-bit mode field and two sample counts complete the setup. The status outputs are a conversion-ready flag, a trigger-seen flag and an end-of-straddle flag. A saturating count also reports how many samples collected before the trigger are valid. The pacer timer and the converter are outside this block.

Top module: `acq_trig_ctrl`

## Requirements
- R1: After synchronous reset, conv_start_o is 0, every bit of status_o is 0 and pre_valid_o is 0.
- R2: With mode 000 (polling), a poll_wr_i strobe produces exactly one conv_start_o pulse in the next cycle. Status bit 3 (ready) rises in the cycle after conv_done_i, and it is cleared by the next poll_wr_i or by flag_clr_i. Pacer ticks start nothing in this mode.
- R3: With mode 001 (free pacer) and conversion armed, every pacer tick gives one conv_start_o pulse in the next cycle.
- R4: arm_wr_i enables conversion and halt_wr_i disables it. Ticks after halt_wr_i start nothing.
- R5: With mode 011 (trigger ends window), ticks convert from arming until the accepted trigger. After the trigger, no tick converts.
- R6: With mode 100 (trigger starts window), ticks before the trigger start nothing. After the trigger, exactly total_cnt_i ticks convert, and then conversion stops.
- R7: With mode 101 (straddle), ticks convert from arming. After the trigger, exactly tail_cnt_i more ticks convert. Status bit 5 then goes to 1. It is cleared by flag_clr_i or arm_wr_i.
- R8: Status bit 4 goes to 1 in the cycle after an accepted trigger rising edge and stays at 1 until flag_clr_i.
- R9: In mode 011, pre_valid_o counts the ticks converted before the trigger, saturating at total_cnt_i. Arming clears it to 0.
- R10: Only the first trigger rising edge is accepted. Later edges have no effect on conversions until flag_clr_i.
- R11: Mode codes 010, 110 and 111 never start a conversion, whatever the ticks, triggers or strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pacer_tick_i | input | 1 | One-cycle pacer tick |
| ext_trig_i | input | 1 | External trigger level, synchronous; the rising edge is used |
| poll_wr_i | input | 1 | Software strobe for a single conversion |
| arm_wr_i | input | 1 | Software strobe to enable and arm conversion |
| halt_wr_i | input | 1 | Software strobe to disable conversion |
| flag_clr_i | input | 1 | Software strobe to clear status flags and re-open the trigger |
| conv_done_i | input | 1 | End-of-conversion pulse from the converter |
| mode_i | input | 3 | Acquisition mode code |
| total_cnt_i | input | CNT_W | Sample count N |
| tail_cnt_i | input | CNT_W | Straddle-mode samples after the trigger (N2) |
| conv_start_o | output | 1 | Registered convert-start pulse |
| status_o | output | 8 | Bit 3 ready, bit 4 trigger seen, bit 5 straddle done, others 0 |
| pre_valid_o | output | CNT_W | Valid pre-trigger sample count |

## Verification
Every result is registered once. A convert-start pulse appears in the cycle after the tick or poll strobe that caused it. Each status bit and the pre-trigger count change at the same edge that captures their cause. The bench drives each input 2 ns after a rising edge and reads status right after the following edge, so every value is read one full cycle after its cause. Pulse counts are compared only after two idle cycles have let the last pulse in flight reach the counter.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [2:0] {
    MODE_POLL  = 3'b000,
    MODE_PACER = 3'b001,
    MODE_PRE   = 3'b011,
    MODE_POST  = 3'b100,
    MODE_MID   = 3'b101
  } acq_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_WAIT,
    ST_TAIL,
    ST_DONE
  } acq_state_e;

  localparam int STAT_W       = 8;
  localparam int STAT_READY   = 3;
  localparam int STAT_TRIG    = 4;
  localparam int STAT_MIDDONE = 5;
endpackage

// File: rtl/acq_trig_latch.sv
module acq_trig_latch (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  input  logic accept_i,
  input  logic clr_i,
  output logic hit_o,
  output logic active_o
);
  logic prev_q;
  logic active_q;

  assign hit_o    = trig_i && !prev_q && accept_i && !active_q && !clr_i;
  assign active_o = active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      prev_q <= trig_i;
      if (clr_i)      active_q <= 1'b0;
      else if (hit_o) active_q <= 1'b1;
    end
  end

  // R10
  trig_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active_q && !clr_i) |=> active_q);
  // R8
  trig_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !active_q);
endmodule

// File: rtl/acq_down_cnt.sv
module acq_down_cnt #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (load_i)              cnt_q <= load_val_i;
    else if (dec_i && cnt_q != 0) cnt_q <= cnt_q - ONE;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == ONE);

  // R6
  cnt_nowrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/acq_sat_cnt.sv
module acq_sat_cnt #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                           cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (inc_i && cnt_q < limit_i) cnt_q <= cnt_q + ONE;
  end

  assign cnt_o = cnt_q;

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && cnt_q >= limit_i) |=> $stable(cnt_q));
  // R9
  sat_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl
  import acq_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pacer_tick_i,
  input  logic              ext_trig_i,
  input  logic              poll_wr_i,
  input  logic              arm_wr_i,
  input  logic              halt_wr_i,
  input  logic              flag_clr_i,
  input  logic              conv_done_i,
  input  logic [2:0]        mode_i,
  input  logic [CNT_W-1:0]  total_cnt_i,
  input  logic [CNT_W-1:0]  tail_cnt_i,
  output logic              conv_start_o,
  output logic [STAT_W-1:0] status_o,
  output logic [CNT_W-1:0]  pre_valid_o
);
  acq_state_e st_q, st_d;
  logic conv_go, conv_q;
  logic rdy_q, pend_q, mid_end_q;
  logic trig_hit, trig_active, accept;
  logic cnt_load, cnt_last;
  logic [CNT_W-1:0] cnt_val, load_val;
  logic pre_inc;
  logic is_pre, is_post, is_mid, is_poll, is_pacer;
  logic mid_set;

  assign is_poll  = (mode_i == MODE_POLL);
  assign is_pacer = (mode_i == MODE_PACER);
  assign is_pre   = (mode_i == MODE_PRE);
  assign is_post  = (mode_i == MODE_POST);
  assign is_mid   = (mode_i == MODE_MID);

  assign accept = (st_q == ST_RUN && (is_pre || is_mid)) || (st_q == ST_WAIT);

  acq_trig_latch u_trig (
    .clk(clk), .rst(rst), .trig_i(ext_trig_i), .accept_i(accept),
    .clr_i(flag_clr_i), .hit_o(trig_hit), .active_o(trig_active)
  );

  acq_down_cnt #(.W(CNT_W)) u_tail (
    .clk(clk), .rst(rst), .load_i(cnt_load), .load_val_i(load_val),
    .dec_i(st_q == ST_TAIL && pacer_tick_i), .cnt_o(cnt_val), .last_o(cnt_last)
  );

  assign pre_inc = (st_q == ST_RUN) && is_pre && pacer_tick_i && !trig_hit;

  acq_sat_cnt #(.W(CNT_W)) u_pre (
    .clk(clk), .rst(rst), .clr_i(arm_wr_i), .inc_i(pre_inc),
    .limit_i(total_cnt_i), .cnt_o(pre_valid_o)
  );

  always_comb begin
    st_d     = st_q;
    conv_go  = 1'b0;
    cnt_load = 1'b0;
    load_val = is_mid ? tail_cnt_i : total_cnt_i;
    mid_set  = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        conv_go = pacer_tick_i && !(is_pre && trig_hit);
        if (trig_hit) begin
          if (is_pre) st_d = ST_DONE;
          else if (tail_cnt_i == '0) begin
            st_d    = ST_DONE;
            mid_set = 1'b1;
          end else begin
            st_d     = ST_TAIL;
            cnt_load = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (trig_hit) begin
          if (total_cnt_i == '0) st_d = ST_DONE;
          else begin
            st_d     = ST_TAIL;
            cnt_load = 1'b1;
          end
        end
      end
      ST_TAIL: begin
        conv_go = pacer_tick_i;
        if (pacer_tick_i && (cnt_last || cnt_val == '0)) begin
          st_d    = ST_DONE;
          mid_set = is_mid;
        end
      end
      default: ;
    endcase
    if (is_poll && poll_wr_i) conv_go = 1'b1;
    if (halt_wr_i) st_d = ST_IDLE;
    else if (arm_wr_i) begin
      if (is_pacer || is_pre || is_mid) st_d = ST_RUN;
      else if (is_post)                 st_d = ST_WAIT;
      else                              st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      conv_q    <= 1'b0;
      rdy_q     <= 1'b0;
      pend_q    <= 1'b0;
      mid_end_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      conv_q <= conv_go;
      if (flag_clr_i) begin
        rdy_q  <= 1'b0;
        pend_q <= 1'b0;
      end else if (is_poll && poll_wr_i) begin
        rdy_q  <= 1'b0;
        pend_q <= 1'b1;
      end else if (conv_done_i && pend_q) begin
        rdy_q  <= 1'b1;
        pend_q <= 1'b0;
      end
      if (flag_clr_i || arm_wr_i) mid_end_q <= 1'b0;
      else if (mid_set)           mid_end_q <= 1'b1;
    end
  end

  assign conv_start_o = conv_q;
  always_comb begin
    status_o               = '0;
    status_o[STAT_READY]   = rdy_q;
    status_o[STAT_TRIG]    = trig_active;
    status_o[STAT_MIDDONE] = mid_end_q;
  end

  // R3
  pacer_conv_chk: assert property (@(posedge clk) disable iff (rst)
    (is_pacer && st_q == ST_RUN && pacer_tick_i) |=> conv_start_o);
  // R5
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DONE && !is_poll) |=> !conv_start_o);
  // R6
  wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT && !is_poll) |=> !conv_start_o);
  // R7
  mid_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mid_end_q) |-> $past(is_mid));
  // R2
  rdy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_q) |-> $past(conv_done_i));
  // R11
  bad_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (!(is_poll || is_pacer || is_pre || is_post || is_mid) &&
     $past(!(is_poll || is_pacer || is_pre || is_post || is_mid))) |-> !conv_start_o);
endmodule

// File: tb/tb_acq_trig_ctrl.sv
module tb_acq_trig_ctrl;
  localparam int CNT_W = 10;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pacer_tick = 0, ext_trig = 0, poll_wr = 0, arm_wr = 0, halt_wr = 0;
  logic flag_clr = 0, conv_done = 0;
  logic [2:0] mode = 3'b000;
  logic [CNT_W-1:0] total_cnt = '0, tail_cnt = '0;
  logic conv_start;
  logic [7:0] status;
  logic [CNT_W-1:0] pre_valid;

  int checks = 0, errors = 0, pulses = 0;
  int exp_n[$];
  string exp_tag[$];
  bit finished = 0;

  always #4 clk = ~clk;

  acq_trig_ctrl #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .pacer_tick_i(pacer_tick), .ext_trig_i(ext_trig),
    .poll_wr_i(poll_wr), .arm_wr_i(arm_wr), .halt_wr_i(halt_wr),
    .flag_clr_i(flag_clr), .conv_done_i(conv_done), .mode_i(mode),
    .total_cnt_i(total_cnt), .tail_cnt_i(tail_cnt),
    .conv_start_o(conv_start), .status_o(status), .pre_valid_o(pre_valid)
  );

  // monitor: counts pulses, pops expected counts from the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (conv_start) pulses++;
      if (exp_n.size() > 0) begin
        int e;
        string t;
        e = exp_n.pop_front();
        t = exp_tag.pop_front();
        checks++;
        if (pulses != e) begin
          errors++;
          $display("FAIL %s: conversions actual %0d expected %0d", t, pulses, e);
        end
        pulses = 0;
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic close_phase(input int n, input string tag);
    cyc(); cyc();
    exp_n.push_back(n);
    exp_tag.push_back(tag);
    cyc();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      pacer_tick = 1; cyc(); pacer_tick = 0; cyc();
    end
  endtask

  task automatic s_poll();  poll_wr = 1;   cyc(); poll_wr = 0;   cyc(); endtask
  task automatic s_arm();   arm_wr = 1;    cyc(); arm_wr = 0;    cyc(); endtask
  task automatic s_halt();  halt_wr = 1;   cyc(); halt_wr = 0;   cyc(); endtask
  task automatic s_clr();   flag_clr = 1;  cyc(); flag_clr = 0;  cyc(); endtask
  task automatic s_done();  conv_done = 1; cyc(); conv_done = 0; cyc(); endtask
  task automatic s_trig();  ext_trig = 1;  cyc(); ext_trig = 0;  cyc(); endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(); cyc(); cyc();
    // R1 reset state
    chk(conv_start, 0, "R1 conv_start");
    chk(status, 0, "R1 status");
    chk(pre_valid, 0, "R1 pre_valid");
    rst = 0; cyc();
    close_phase(0, "R1");

    // R2 polling
    mode = 3'b000;
    s_poll();
    close_phase(1, "R2 poll");
    chk(status[3], 0, "R2 ready before done");
    s_done();
    chk(status[3], 1, "R2 ready after done");
    s_poll();
    chk(status[3], 0, "R2 ready cleared by poll");
    close_phase(1, "R2 second poll");
    s_clr();
    s_arm(); ticks(3);
    close_phase(0, "R2 ticks ignored in polling");

    // R3 / R4 free pacer
    mode = 3'b001;
    s_arm(); ticks(5);
    close_phase(5, "R3 pacer");
    s_halt(); ticks(3);
    close_phase(0, "R4 halted");

    // R5 / R8 / R9 trigger ends window
    mode = 3'b011; total_cnt = 4;
    s_clr(); s_arm(); ticks(6);
    close_phase(6, "R5 pre run");
    chk(pre_valid, 4, "R9 saturated");
    chk(status[4], 0, "R8 before trigger");
    s_trig();
    chk(status[4], 1, "R8 after trigger");
    ticks(3);
    close_phase(0, "R5 after trigger");
    s_clr();
    chk(status[4], 0, "R8 cleared");
    s_arm(); ticks(2); s_trig();
    chk(pre_valid, 2, "R9 partial");
    close_phase(2, "R5 short");

    // R6 trigger starts window
    mode = 3'b100; total_cnt = 3;
    s_clr(); s_arm(); ticks(2);
    close_phase(0, "R6 before trigger");
    s_trig(); ticks(5);
    close_phase(3, "R6 after trigger");

    // R10 later edges ignored until clear
    s_arm(); s_trig(); ticks(4);
    close_phase(0, "R10 edge ignored");
    chk(status[4], 1, "R10 flag held");
    s_clr(); s_trig(); ticks(4);
    close_phase(3, "R10 after clear");

    // R7 straddle
    mode = 3'b101; total_cnt = 6; tail_cnt = 2;
    s_clr(); s_arm(); ticks(5);
    close_phase(5, "R7 before trigger");
    s_trig();
    chk(status[5], 0, "R7 end flag low");
    ticks(1);
    chk(status[5], 0, "R7 end flag after one");
    ticks(3);
    close_phase(2, "R7 tail count");
    chk(status[5], 1, "R7 end flag set");
    s_clr();
    chk(status[5], 0, "R7 end flag cleared");

    // R11 unused codes
    mode = 3'b110;
    s_clr(); s_arm(); ticks(3); s_trig(); ticks(2); s_poll();
    close_phase(0, "R11 code 110");
    mode = 3'b010;
    s_arm(); ticks(3); s_poll();
    close_phase(0, "R11 code 010");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule